// File: doc/BRIEF.md
# Tone Guard Qualifier

This block turns a noisy tone-detect level from an analog detector into a clean "tone valid" indication. A tone must be present without a break for a programmable number of guard ticks before it is accepted, and must then be absent without a break for another programmable number of ticks before it is dropped. A shorter blip in either direction restarts the timing and leaves the qualified output where it was. The guard ticks come from an on-block prescaler whose divide value is a register input. With a divide value of 3071 and a 3.58 MHz clock, the tick period is close to 0.858 ms.

Each accepted tone raises a sticky event flag, which software clears with a clear strobe. The block has two modes. In alert-tone mode it uses one pair of guard limits and never touches the code register. In DTMF mode it uses a second pair of limits and captures the 4-bit decoded digit on each accepted tone. A global enable holds the timers and the qualified output cleared.

Top module: `tone_guard_qual`

## Requirements
- R1: After reset, `valid_o`, `flag_o` and `code_o` are all 0.
- R2: Guard time is counted in ticks. A tick is one clock cycle in every `div_val_i`+1 cycles while enabled. The tick counter is held at 0 while disabled.
- R3: `valid_o` rises only after `raw_det_i` has been high without a break for the presence limit in ticks. A high pulse shorter than that leaves `valid_o` at 0, and the next rising edge restarts the count from zero.
- R4: `valid_o` falls only after `raw_det_i` has been low without a break for the absence limit in ticks.
- R5: A dropout of `raw_det_i` shorter than the absence limit leaves `valid_o` at 1.
- R6: `flag_o` goes to 1 one cycle after each rising edge of `valid_o`. It stays 1 until `flag_clr_i` is sampled high. While `valid_o` stays high, `flag_o` does not set again.
- R7: If the clear strobe and a new rising edge of `valid_o` fall in the same cycle, the flag is set.
- R8: When `mode_dtmf_i`=1, `code_o` takes `code_i` on each rising edge of `valid_o` and holds it otherwise. When `mode_dtmf_i`=0, `code_o` never changes.
- R9: `mode_dtmf_i`=0 selects the limits `pres_alert_i`/`abs_alert_i`. `mode_dtmf_i`=1 selects `pres_dtmf_i`/`abs_dtmf_i`.
- R10: With `enable_i`=0, `valid_o` is 0 from the next clock and `raw_det_i` has no effect. `flag_o` and `code_o` keep their values. If `enable_i` returns with the raw signal high, this counts as a new rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable_i | input | 1 | Global detector enable |
| div_val_i | input | DIV_W | Tick prescaler divide value (period = value+1 clocks) |
| mode_dtmf_i | input | 1 | 0 = alert-tone limits, 1 = DTMF limits and code capture |
| pres_alert_i | input | GUARD_W | Presence limit in ticks, alert mode |
| abs_alert_i | input | GUARD_W | Absence limit in ticks, alert mode |
| pres_dtmf_i | input | GUARD_W | Presence limit in ticks, DTMF mode |
| abs_dtmf_i | input | GUARD_W | Absence limit in ticks, DTMF mode |
| raw_det_i | input | 1 | Unqualified tone-detect level |
| code_i | input | CODE_W | Decoded digit from the tone decoder |
| flag_clr_i | input | 1 | Software clear strobe for the event flag |
| valid_o | output | 1 | Qualified tone-present output |
| flag_o | output | 1 | Sticky event flag |
| code_o | output | CODE_W | Captured digit |

## Verification
The bench drives pulses just below and just above each guard window, in both modes, because the two pairs of limits differ. A design that uses the wrong pair, or that keeps counting across a glitch instead of restarting, would accept or drop the tone at the wrong time.

It holds the clear strobe high through a tone acquisition and watches for a one-cycle flag pulse. If the clear wins in a collision, that pulse never appears.

It changes the digit while the tone stays valid and checks that `code_o` does not follow. It also disables the block with the tone present and then re-enables it. A design that does not restart the presence guard on re-enable would show a stale valid immediately.

// File: rtl/tgq_pkg.sv
package tgq_pkg;
    typedef enum logic {
        GUARD_ALERT = 1'b0,
        GUARD_DTMF  = 1'b1
    } guard_sel_e;
endpackage

// File: rtl/tgq_tick_gen.sv
module tgq_tick_gen #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [DIV_W-1:0] div_val_i,
    output logic             tick_o
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } tick_st_t;

    tick_st_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        tick_o = 1'b0;
        if (!en_i) begin
            st_d.cnt = '0;
        end else if (st_q.cnt >= div_val_i) begin
            st_d.cnt = '0;
            tick_o   = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/tgq_guard_timer.sv
module tgq_guard_timer #(
    parameter int GUARD_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en_i,
    input  logic               tick_i,
    input  logic               raw_i,
    input  logic [GUARD_W-1:0] pres_lim_i,
    input  logic [GUARD_W-1:0] abs_lim_i,
    output logic               valid_o
);
    typedef struct packed {
        logic               raw;
        logic               run;
        logic               valid;
        logic [GUARD_W-1:0] cnt;
    } guard_st_t;

    guard_st_t          st_d, st_q;
    logic [GUARD_W-1:0] lim;

    always_comb begin
        st_d = st_q;
        lim  = st_q.raw ? pres_lim_i : abs_lim_i;
        if (!en_i) begin
            st_d = '0;
        end else if (raw_i != st_q.raw) begin
            // any edge of the raw level restarts the guard window
            st_d.raw = raw_i;
            st_d.cnt = '0;
            st_d.run = 1'b1;
        end else if (st_q.run) begin
            if (st_q.cnt >= lim) begin
                st_d.run   = 1'b0;
                st_d.valid = st_q.raw;
            end else if (tick_i) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign valid_o = st_q.valid;
endmodule

// File: rtl/tgq_event_latch.sv
module tgq_event_latch #(
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic              flag_clr_i,
    input  logic              capture_en_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              flag_o,
    output logic [CODE_W-1:0] code_o
);
    typedef struct packed {
        logic              vprev;
        logic              flag;
        logic [CODE_W-1:0] code;
    } evt_st_t;

    evt_st_t st_d, st_q;
    logic    rise;

    always_comb begin
        st_d       = st_q;
        rise       = valid_i & ~st_q.vprev;
        st_d.vprev = valid_i;
        // a new event outranks a simultaneous clear
        if (rise)            st_d.flag = 1'b1;
        else if (flag_clr_i) st_d.flag = 1'b0;
        if (rise && capture_en_i) st_d.code = code_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o = st_q.flag;
    assign code_o = st_q.code;
endmodule

// File: rtl/tone_guard_qual.sv
module tone_guard_qual #(
    parameter int DIV_W   = 12,
    parameter int GUARD_W = 8,
    parameter int CODE_W  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable_i,
    input  logic [DIV_W-1:0]   div_val_i,
    input  logic               mode_dtmf_i,
    input  logic [GUARD_W-1:0] pres_alert_i,
    input  logic [GUARD_W-1:0] abs_alert_i,
    input  logic [GUARD_W-1:0] pres_dtmf_i,
    input  logic [GUARD_W-1:0] abs_dtmf_i,
    input  logic               raw_det_i,
    input  logic [CODE_W-1:0]  code_i,
    input  logic               flag_clr_i,
    output logic               valid_o,
    output logic               flag_o,
    output logic [CODE_W-1:0]  code_o
);
    import tgq_pkg::*;

    guard_sel_e         sel;
    logic               tick;
    logic [GUARD_W-1:0] pres_lim, abs_lim;

    assign sel = guard_sel_e'(mode_dtmf_i);

    always_comb begin
        if (sel == GUARD_DTMF) begin
            pres_lim = pres_dtmf_i;
            abs_lim  = abs_dtmf_i;
        end else begin
            pres_lim = pres_alert_i;
            abs_lim  = abs_alert_i;
        end
    end

    tgq_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (enable_i),
        .div_val_i (div_val_i),
        .tick_o    (tick)
    );

    tgq_guard_timer #(.GUARD_W(GUARD_W)) u_guard (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (enable_i),
        .tick_i     (tick),
        .raw_i      (raw_det_i),
        .pres_lim_i (pres_lim),
        .abs_lim_i  (abs_lim),
        .valid_o    (valid_o)
    );

    tgq_event_latch #(.CODE_W(CODE_W)) u_evt (
        .clk          (clk),
        .rst_n        (rst_n),
        .valid_i      (valid_o),
        .flag_clr_i   (flag_clr_i),
        .capture_en_i (sel == GUARD_DTMF),
        .code_i       (code_i),
        .flag_o       (flag_o),
        .code_o       (code_o)
    );
endmodule

// File: rtl/tgq_checker.sv
module tgq_checker #(
    parameter int CODE_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enable_i,
    input logic              mode_dtmf_i,
    input logic              raw_det_i,
    input logic              flag_clr_i,
    input logic              valid_o,
    input logic              flag_o,
    input logic [CODE_W-1:0] code_o
);
    assert_rise_needs_tone_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_o) |-> $past(raw_det_i && enable_i));

    assert_fall_needs_loss_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(valid_o) |-> $past(!raw_det_i || !enable_i));

    assert_flag_follows_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_o) |=> flag_o);

    assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !flag_clr_i) |=> flag_o);

    assert_disable_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> !valid_o);

    assert_code_only_on_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(code_o) |-> ($past(valid_o) && !$past(valid_o, 2) && $past(mode_dtmf_i)));
endmodule

bind tone_guard_qual tgq_checker #(.CODE_W(CODE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable_i    (enable_i),
    .mode_dtmf_i (mode_dtmf_i),
    .raw_det_i   (raw_det_i),
    .flag_clr_i  (flag_clr_i),
    .valid_o     (valid_o),
    .flag_o      (flag_o),
    .code_o      (code_o)
);

// File: tb/tone_guard_qual_tb.sv
module tone_guard_qual_tb;
    localparam int DIV_W   = 12;
    localparam int GUARD_W = 8;
    localparam int CODE_W  = 4;
    localparam int DIV     = 3;          // tick every 4 clocks
    localparam int TP      = DIV + 1;
    localparam int PA = 5, AA = 4, PD = 3, AD = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0;
    logic mode = 1'b0;
    logic raw = 1'b0;
    logic clr = 1'b0;
    logic [CODE_W-1:0] code_in = '0;
    logic valid, flag;
    logic [CODE_W-1:0] code_out;

    always #4 clk = ~clk;

    tone_guard_qual #(.DIV_W(DIV_W), .GUARD_W(GUARD_W), .CODE_W(CODE_W)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable_i     (enable),
        .div_val_i    (DIV_W'(DIV)),
        .mode_dtmf_i  (mode),
        .pres_alert_i (GUARD_W'(PA)),
        .abs_alert_i  (GUARD_W'(AA)),
        .pres_dtmf_i  (GUARD_W'(PD)),
        .abs_dtmf_i   (GUARD_W'(AD)),
        .raw_det_i    (raw),
        .code_i       (code_in),
        .flag_clr_i   (clr),
        .valid_o      (valid),
        .flag_o       (flag),
        .code_o       (code_out)
    );

    typedef struct {
        logic              v;
        logic              f;
        logic [CODE_W-1:0] c;
        string             tag;
    } exp_t;

    exp_t exp_q[$];
    int checks = 0;
    int fails = 0;
    logic flag_seen = 1'b0;
    bit done = 1'b0;

    // monitor: compares queued expectations away from the active edge
    always @(negedge clk) begin
        if (flag) flag_seen <= 1'b1;
        while (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            if (valid !== e.v || flag !== e.f || code_out !== e.c) begin
                fails++;
                $display("FAIL %s: valid/flag/code act=%b/%b/%h exp=%b/%b/%h",
                         e.tag, valid, flag, code_out, e.v, e.f, e.c);
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic expect_out(input logic v, input logic f, input logic [CODE_W-1:0] c,
                              input string tag);
        exp_t e;
        e.v = v; e.f = f; e.c = c; e.tag = tag;
        exp_q.push_back(e);
        wait (exp_q.size() == 0);
    endtask

    task automatic pulse_clear();
        clr = 1'b1; step(1); clr = 1'b0; step(1);
    endtask

    initial begin
        step(3);
        expect_out(1'b0, 1'b0, 4'h0, "R1 reset state");
        rst_n = 1'b1; enable = 1'b1;
        step(2);

        // alert mode: glitch shorter than presence guard
        raw = 1'b1; step((PA - 1) * TP - 6);
        raw = 1'b0; step(2);
        expect_out(1'b0, 1'b0, 4'h0, "R3 short pulse rejected");

        code_in = 4'h7;
        raw = 1'b1; step(PA * TP + 4);
        expect_out(1'b1, 1'b1, 4'h0, "R3/R8 accepted, no capture in alert mode");
        pulse_clear();
        expect_out(1'b1, 1'b0, 4'h0, "R6 flag cleared");

        raw = 1'b0; step((AA - 1) * TP - 6);
        raw = 1'b1; step(2);
        expect_out(1'b1, 1'b0, 4'h0, "R5 dropout ignored");
        step(PA * TP + 4);
        expect_out(1'b1, 1'b0, 4'h0, "R6 no re-set without new rise");

        raw = 1'b0; step(AA * TP + 4);
        expect_out(1'b0, 1'b0, 4'h0, "R4 absence guard clears valid");

        // collision: clear held high across acquisition
        flag_seen = 1'b0; clr = 1'b1;
        raw = 1'b1; step(PA * TP + 4);
        checks++;
        if (flag_seen !== 1'b1) begin
            fails++;
            $display("FAIL R7 set over clear: flag_seen act=%b exp=1", flag_seen);
        end
        expect_out(1'b1, 1'b0, 4'h0, "R7 flag cleared after pulse");
        raw = 1'b0; step(AA * TP + 4);
        clr = 1'b0;

        // DTMF mode: shorter presence limit than alert mode
        mode = 1'b1; code_in = 4'h9;
        raw = 1'b1; step(16);
        expect_out(1'b1, 1'b1, 4'h9, "R9/R8 dtmf presence limit and capture");
        pulse_clear();
        code_in = 4'h3; step(4);
        expect_out(1'b1, 1'b0, 4'h9, "R8 code held while valid");

        raw = 1'b0; step(20);
        expect_out(1'b1, 1'b0, 4'h9, "R9 dtmf absence limit longer than alert");
        raw = 1'b1; step(2);
        expect_out(1'b1, 1'b0, 4'h9, "R5 dtmf dropout ignored");

        raw = 1'b0; step(AD * TP + 4);
        expect_out(1'b0, 1'b0, 4'h9, "R4 dtmf absence clears valid");
        code_in = 4'h5;
        raw = 1'b1; step(PD * TP + 4);
        expect_out(1'b1, 1'b1, 4'h5, "R8 new digit captured");

        // global enable
        enable = 1'b0; step(1);
        expect_out(1'b0, 1'b1, 4'h5, "R10 disable clears valid");
        code_in = 4'hC; raw = 1'b0; step(10); raw = 1'b1; step(30);
        expect_out(1'b0, 1'b1, 4'h5, "R10 raw ignored while disabled");
        enable = 1'b1; step(1);
        expect_out(1'b0, 1'b1, 4'h5, "R10 presence guard restarts on enable");
        step(PD * TP + 4);
        expect_out(1'b1, 1'b1, 4'hC, "R2/R10 reacquired after enable");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: act=timeout exp=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule